// File: doc/BRIEF.md
# Data-Side Bus Master with Wait-State Stall

This block sits between the load/store stage of a small processor core and a memory-mapped bus that may insert wait states. The core presents one load or store per instruction: an address, write data, byte-lane enables and a write flag. The block puts that request on the bus and keeps it there, unchanged, for as long as the addressed slave holds its waitrequest line high. Meanwhile it holds the core with a stall signal. A store that the slave takes in its first cycle costs no stall at all.

A load is accepted like a store. The slave returns its data on the bus one cycle after acceptance, and the block registers that word. In the following cycle the block lowers the stall and flags the word as valid. The registered word stays on the core-side data output until the next load replaces it. Only one transfer is ever outstanding. Instruction fetch uses a separate port that this block does not touch.

Top module: `dbus_stall_unit`

## Requirements
- R1: While read or write is high and waitrequest is high, the next cycle shows the same read, write, address, byteenable and writedata values on the bus.
- R2: A store whose waitrequest is low in its issue cycle completes in that cycle with core_stall low.
- R3: core_stall is high in every cycle where a transfer is on the bus and waitrequest is high. A store that meets N wait cycles stalls the core for exactly N cycles.
- R4: A load that meets N wait cycles stalls the core for N+2 cycles. The bus readdata is sampled in the cycle after acceptance. The cycle after that has core_stall low and core_rvalid high, with the loaded word on core_rdata.
- R5: Each core request produces exactly one accepted bus transfer. Read and write are never high together. Both are low in the cycle after a read is accepted.
- R6: In the cycle where core_rvalid is high, the core request inputs are ignored: no bus transfer is started, even though the finishing load is still presented.
- R7: core_rdata changes only when a new load word is delivered (core_rvalid high) and otherwise keeps the last loaded word.
- R8: With ALIGN_ADDR set, the low log2(DATA_W/8) bits of the bus address are driven as zero. Byteenable selects the lanes, bit k for bits 8k+7..8k of the word, and is passed through unchanged.
- R9: During and straight after reset, read and write are low, core_stall is low and core_rvalid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core presents a load or store this cycle |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | ADDR_W | Byte address from the core |
| core_wdata | input | DATA_W | Store data |
| core_be | input | DATA_W/8 | Byte-lane enables |
| core_stall | output | 1 | Hold the core's load/store stage |
| core_rdata | output | DATA_W | Last loaded word, held |
| core_rvalid | output | 1 | Load word delivered this cycle |
| avm_address | output | ADDR_W | Bus byte address |
| avm_read | output | 1 | Bus read request |
| avm_write | output | 1 | Bus write request |
| avm_byteenable | output | DATA_W/8 | Bus byte-lane enables |
| avm_writedata | output | DATA_W | Bus write data |
| avm_readdata | input | DATA_W | Bus read data, one cycle after acceptance |
| avm_waitrequest | input | 1 | Slave not ready; request must be held |

## Verification
The bench builds the block with a 16-bit address, a 32-bit word and address alignment switched on. These values give four byte lanes, so partial-lane stores and the zeroing of two low address bits can be observed against a sixteen-word bus slave. The slave takes a per-transfer wait count, ranging from zero to several dozen, which reaches the no-stall store, long held requests and back-to-back loads. On every idle cycle the slave drives random readdata, so a word captured one cycle early or late shows up as a mismatch.

// File: rtl/dsu_pkg.sv
package dsu_pkg;

   // Transfer sequencer states
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,   // no transfer held; a core request goes straight to the bus
      ST_REQ    = 2'd1,   // request latched, slave asserting wait
      ST_RDWAIT = 2'd2,   // read accepted, data on the bus this cycle
      ST_RESP   = 2'd3    // load word delivered to the core
   } dsu_state_e;

   function automatic int unsigned lane_bits(input int unsigned data_w);
      return (data_w <= 8) ? 0 : $clog2(data_w / 8);
   endfunction

endpackage

// File: rtl/dsu_req_hold.sv
module dsu_req_hold #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BE_W   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              sel_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [BE_W-1:0]   be_i,
   output logic              lat_we_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic [BE_W-1:0]   be_o
);

   logic              we_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [BE_W-1:0]   be_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
      end else if (load_i) begin
         we_q    <= we_i;
         addr_q  <= addr_i;
         wdata_q <= wdata_i;
         be_q    <= be_i;
      end
   end

   assign lat_we_o = we_q;
   assign addr_o   = sel_i ? addr_q  : addr_i;
   assign wdata_o  = sel_i ? wdata_q : wdata_i;
   assign be_o     = sel_i ? be_q    : be_i;

endmodule

// File: rtl/dsu_ctrl.sv
module dsu_ctrl
   import dsu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic core_req_i,
   input  logic core_we_i,
   input  logic lat_we_i,
   input  logic bus_wait_i,
   output logic load_o,
   output logic use_lat_o,
   output logic bus_rd_o,
   output logic bus_wr_o,
   output logic stall_o,
   output logic cap_o,
   output logic rvalid_o
);

   dsu_state_e st_q, st_d;

   always_comb begin
      st_d      = st_q;
      load_o    = 1'b0;
      use_lat_o = 1'b0;
      bus_rd_o  = 1'b0;
      bus_wr_o  = 1'b0;
      stall_o   = 1'b0;
      cap_o     = 1'b0;
      rvalid_o  = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (core_req_i) begin
               bus_rd_o = !core_we_i;
               bus_wr_o = core_we_i;
               load_o   = 1'b1;
               stall_o  = bus_wait_i || !core_we_i;
               if (bus_wait_i)      st_d = ST_REQ;
               else if (!core_we_i) st_d = ST_RDWAIT;
            end
         end
         ST_REQ: begin
            use_lat_o = 1'b1;
            bus_rd_o  = !lat_we_i;
            bus_wr_o  = lat_we_i;
            stall_o   = bus_wait_i || !lat_we_i;
            if (!bus_wait_i) st_d = lat_we_i ? ST_IDLE : ST_RDWAIT;
         end
         ST_RDWAIT: begin
            stall_o = 1'b1;
            cap_o   = 1'b1;
            st_d    = ST_RESP;
         end
         ST_RESP: begin
            rvalid_o = 1'b1;
            st_d     = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/dsu_load_buf.sv
module dsu_load_buf #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [DATA_W-1:0] bus_rdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_o <= '0;
      else if (cap_i) rdata_o <= bus_rdata_i;
   end

endmodule

// File: rtl/dbus_stall_unit.sv
module dbus_stall_unit #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter bit          ALIGN_ADDR = 1'b1,
   localparam int unsigned BE_W      = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_req,
   input  logic              core_we,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic [DATA_W-1:0] core_wdata,
   input  logic [BE_W-1:0]   core_be,
   output logic              core_stall,
   output logic [DATA_W-1:0] core_rdata,
   output logic              core_rvalid,
   output logic [ADDR_W-1:0] avm_address,
   output logic              avm_read,
   output logic              avm_write,
   output logic [BE_W-1:0]   avm_byteenable,
   output logic [DATA_W-1:0] avm_writedata,
   input  logic [DATA_W-1:0] avm_readdata,
   input  logic              avm_waitrequest
);

   localparam int unsigned LANE_W = dsu_pkg::lane_bits(DATA_W);
   localparam logic [ADDR_W-1:0] LANE_MASK = ADDR_W'((64'd1 << LANE_W) - 64'd1);

   // Elaboration-time parameter checks
   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data_w
         $error("DATA_W must be a non-zero multiple of 8");
      end
      if ((BE_W & (BE_W - 1)) != 0) begin : g_bad_lanes
         $error("DATA_W/8 must be a power of two");
      end
      if (ADDR_W <= LANE_W) begin : g_bad_addr_w
         $error("ADDR_W must exceed the byte-lane address bits");
      end
   endgenerate

   logic              load_w, use_lat_w, lat_we_w, cap_w;
   logic [ADDR_W-1:0] sel_addr_w;

   dsu_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .core_req_i (core_req),
      .core_we_i  (core_we),
      .lat_we_i   (lat_we_w),
      .bus_wait_i (avm_waitrequest),
      .load_o     (load_w),
      .use_lat_o  (use_lat_w),
      .bus_rd_o   (avm_read),
      .bus_wr_o   (avm_write),
      .stall_o    (core_stall),
      .cap_o      (cap_w),
      .rvalid_o   (core_rvalid)
   );

   dsu_req_hold #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BE_W   (BE_W)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_w),
      .sel_i    (use_lat_w),
      .we_i     (core_we),
      .addr_i   (core_addr),
      .wdata_i  (core_wdata),
      .be_i     (core_be),
      .lat_we_o (lat_we_w),
      .addr_o   (sel_addr_w),
      .wdata_o  (avm_writedata),
      .be_o     (avm_byteenable)
   );

   dsu_load_buf #(
      .DATA_W (DATA_W)
   ) u_lbuf (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_i       (cap_w),
      .bus_rdata_i (avm_readdata),
      .rdata_o     (core_rdata)
   );

   // Address presentation variant
   generate
      if (ALIGN_ADDR) begin : g_align
         assign avm_address = sel_addr_w & ~LANE_MASK;
      end else begin : g_pass
         assign avm_address = sel_addr_w;
      end
   endgenerate

endmodule

// File: rtl/dbus_stall_unit_chk.sv
module dbus_stall_unit_chk #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter bit          ALIGN_ADDR = 1'b1,
   localparam int unsigned BE_W      = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              core_stall,
   input logic [DATA_W-1:0] core_rdata,
   input logic              core_rvalid,
   input logic [ADDR_W-1:0] avm_address,
   input logic              avm_read,
   input logic              avm_write,
   input logic [BE_W-1:0]   avm_byteenable,
   input logic [DATA_W-1:0] avm_writedata,
   input logic              avm_waitrequest
);

   localparam int unsigned LANE_W = dsu_pkg::lane_bits(DATA_W);
   localparam logic [ADDR_W-1:0] LANE_MASK = ADDR_W'((64'd1 << LANE_W) - 64'd1);

   logic xfer_w, held_w, rd_acc_w;
   assign xfer_w   = avm_read || avm_write;
   assign held_w   = xfer_w && avm_waitrequest;
   assign rd_acc_w = avm_read && !avm_waitrequest;

   a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      held_w |=> (avm_read == $past(avm_read)) && (avm_write == $past(avm_write))
                 && $stable(avm_address) && $stable(avm_byteenable) && $stable(avm_writedata));

   a_r2_store_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (avm_write && !avm_waitrequest) |-> !core_stall);

   a_r3_stall_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
      held_w |-> core_stall);

   a_r4_rvalid_timing: assert property (@(posedge clk) disable iff (!rst_n)
      core_rvalid |-> $past(rd_acc_w, 2));

   a_r5_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({avm_read, avm_write}));

   a_r5_gap_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc_w |=> !avm_read && !avm_write);

   a_r6_resp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      core_rvalid |-> !avm_read && !avm_write && !core_stall);

   a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(core_rdata) |-> core_rvalid);

   generate
      if (ALIGN_ADDR) begin : g_align_chk
         a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_w |-> ((avm_address & LANE_MASK) == '0));
      end
   endgenerate

   a_r9_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> !avm_read && !avm_write && !core_stall && !core_rvalid);

endmodule

bind dbus_stall_unit dbus_stall_unit_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .ALIGN_ADDR (ALIGN_ADDR)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .core_stall      (core_stall),
   .core_rdata      (core_rdata),
   .core_rvalid     (core_rvalid),
   .avm_address     (avm_address),
   .avm_read        (avm_read),
   .avm_write       (avm_write),
   .avm_byteenable  (avm_byteenable),
   .avm_writedata   (avm_writedata),
   .avm_waitrequest (avm_waitrequest)
);

// File: tb/dbus_stall_unit_tb_top.sv
module dbus_stall_unit_tb_top;

   localparam int unsigned AW = 16;
   localparam int unsigned DW = 32;
   localparam int unsigned BW = DW / 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          core_req = 1'b0, core_we = 1'b0;
   logic [AW-1:0] core_addr = '0;
   logic [DW-1:0] core_wdata = '0;
   logic [BW-1:0] core_be = '0;
   logic          core_stall, core_rvalid;
   logic [DW-1:0] core_rdata;
   logic [AW-1:0] avm_address;
   logic          avm_read, avm_write, avm_waitrequest;
   logic [BW-1:0] avm_byteenable;
   logic [DW-1:0] avm_writedata;
   logic [DW-1:0] rd_q;

   dbus_stall_unit #(.ADDR_W(AW), .DATA_W(DW), .ALIGN_ADDR(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
      .core_wdata(core_wdata), .core_be(core_be),
      .core_stall(core_stall), .core_rdata(core_rdata), .core_rvalid(core_rvalid),
      .avm_address(avm_address), .avm_read(avm_read), .avm_write(avm_write),
      .avm_byteenable(avm_byteenable), .avm_writedata(avm_writedata),
      .avm_readdata(rd_q), .avm_waitrequest(avm_waitrequest)
   );

   // ---------------- bus slave model ----------------
   logic [DW-1:0] smem [16];
   int unsigned wait_cfg = 0;
   int unsigned waited = 0;
   int unsigned xfer_cnt = 0;
   int unsigned hold_err = 0;
   int unsigned misalign = 0;
   logic          prev_held = 1'b0, prev_rd = 1'b0, prev_wr = 1'b0;
   logic [AW-1:0] prev_addr = '0;
   logic [BW-1:0] prev_be = '0;
   logic [DW-1:0] prev_wd = '0;

   function automatic logic [DW-1:0] seed_word(input int i);
      return DW'(32'hA5A5_0000 ^ (i * 32'h0101_0101));
   endfunction

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] wd,
                                           input logic [BW-1:0] be);
      logic [DW-1:0] r = old;
      for (int b = 0; b < BW; b++) if (be[b]) r[8*b +: 8] = wd[8*b +: 8];
      return r;
   endfunction

   function automatic int unsigned exp_stalls(input bit we, input int unsigned n);
      return we ? n : n + 2;
   endfunction

   assign avm_waitrequest = (avm_read || avm_write) && (waited < wait_cfg);

   always @(posedge clk) begin
      rd_q <= DW'($urandom);
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) smem[i] <= seed_word(i);
         waited <= 0;
      end else begin
         if (prev_held && (avm_read != prev_rd || avm_write != prev_wr || avm_address != prev_addr
                           || avm_byteenable != prev_be || avm_writedata != prev_wd))
            hold_err <= hold_err + 1;
         if ((avm_read || avm_write) && avm_address[1:0] != 2'b00) misalign <= misalign + 1;
         if (avm_read || avm_write) begin
            if (avm_waitrequest) waited <= waited + 1;
            else begin
               waited   <= 0;
               xfer_cnt <= xfer_cnt + 1;
               if (avm_write) smem[avm_address[5:2]] <= merge(smem[avm_address[5:2]], avm_writedata, avm_byteenable);
               else           rd_q <= smem[avm_address[5:2]];
            end
         end
      end
      prev_held <= (avm_read || avm_write) && avm_waitrequest;
      prev_rd   <= avm_read;
      prev_wr   <= avm_write;
      prev_addr <= avm_address;
      prev_be   <= avm_byteenable;
      prev_wd   <= avm_writedata;
   end

   // ---------------- checking ----------------
   int unsigned n_checks = 0;
   int unsigned n_fail = 0;
   logic [DW-1:0] exp_mem [16];
   logic [DW-1:0] last_load = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_op(input bit we, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                        input logic [BW-1:0] be, input int unsigned nwait);
      int unsigned stalls = 0;
      int unsigned c0, h0, m0;
      int idx = int'(addr[5:2]);
      @(negedge clk);
      wait_cfg   = nwait;
      core_req   = 1'b1;
      core_we    = we;
      core_addr  = addr;
      core_wdata = wd;
      core_be    = be;
      c0 = xfer_cnt; h0 = hold_err; m0 = misalign;
      #1;
      while (core_stall && stalls < 1000) begin
         stalls++;
         @(negedge clk);
         #1;
      end
      if (we) begin
         // R2 / R3: store stalls exactly once per wait cycle
         chk(stalls == exp_stalls(1'b1, nwait), nwait == 0 ? "R2" : "R3", "store stall cycles",
             DW'(stalls), DW'(exp_stalls(1'b1, nwait)));
         exp_mem[idx] = merge(exp_mem[idx], wd, be);
      end else begin
         // R4: load stall count, delivery flag and data
         chk(stalls == exp_stalls(1'b0, nwait), "R4", "load stall cycles",
             DW'(stalls), DW'(exp_stalls(1'b0, nwait)));
         chk(core_rvalid == 1'b1, "R4", "rvalid on delivery", DW'(core_rvalid), 1);
         chk(core_rdata == exp_mem[idx], "R4", "load data", core_rdata, exp_mem[idx]);
         last_load = exp_mem[idx];
      end
      @(posedge clk);
      #1;
      core_req = 1'b0;
      // R5 / R6: exactly one transfer, none from the delivery cycle
      chk(xfer_cnt == c0 + 1, we ? "R5" : "R6", "transfers per request",
          DW'(xfer_cnt - c0), 1);
      if (nwait > 0) chk(hold_err == h0, "R1", "held request changed", DW'(hold_err - h0), 0);
      chk(misalign == m0, "R8", "unaligned bus address", DW'(misalign - m0), 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      seed = $urandom(32'h1357_9bdf);
      for (int i = 0; i < 16; i++) exp_mem[i] = seed_word(i);
      repeat (3) @(posedge clk);
      #1;
      // R9: quiet outputs in reset
      chk(!avm_read && !avm_write, "R9", "bus idle in reset", DW'({avm_read, avm_write}), 0);
      chk(!core_stall && !core_rvalid, "R9", "core flags in reset", DW'({core_stall, core_rvalid}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!avm_read && !avm_write && !core_stall, "R9", "idle after reset",
          DW'({avm_read, avm_write, core_stall}), 0);

      // directed corner cases
      do_op(1'b1, 16'h0004, 32'hDEAD_BEEF, 4'hF, 0);   // R2 zero-wait store
      do_op(1'b1, 16'h0009, 32'h1122_3344, 4'hF, 5);   // R3, R8 unaligned input
      do_op(1'b0, 16'h0004, '0, 4'hF, 0);              // R4 zero-wait load
      do_op(1'b0, 16'h000B, '0, 4'hF, 7);              // R4 long wait
      do_op(1'b1, 16'h0010, 32'hCAFE_F00D, 4'b0101, 2); // R8 partial lanes
      do_op(1'b0, 16'h0010, '0, 4'hF, 1);
      do_op(1'b0, 16'h0014, '0, 4'hF, 0);              // back-to-back loads
      do_op(1'b0, 16'h0018, '0, 4'hF, 0);
      do_op(1'b0, 16'h003C, '0, 4'hF, 40);             // very long wait

      // R7: load word held across stores and idle cycles
      do_op(1'b0, 16'h0020, '0, 4'hF, 3);
      do_op(1'b1, 16'h0024, 32'h0BAD_0BAD, 4'hF, 1);
      do_op(1'b1, 16'h0028, 32'h7777_0000, 4'b1100, 0);
      repeat (4) @(negedge clk);
      #1;
      chk(core_rdata == last_load, "R7", "load word held", core_rdata, last_load);
      chk(!core_rvalid, "R7", "no delivery while idle", DW'(core_rvalid), 0);

      // constrained random mix
      for (int k = 0; k < 200; k++) begin
         bit            we = 1'($urandom % 2);
         logic [AW-1:0] a  = AW'($urandom % 64);
         logic [DW-1:0] d  = DW'($urandom);
         logic [BW-1:0] b  = BW'(($urandom % 15) + 1);
         do_op(we, a, d, b, $urandom % 6);
      end

      @(negedge clk);
      #1;
      chk(core_rdata == last_load, "R7", "final held word", core_rdata, last_load);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule